// File: doc/BRIEF.md
# System Management Interrupt Entry Sequencer

This block takes a simplified processor core from normal execution into system management mode. An external management request can arrive at any time. The block holds it pending and acts on it only when the core signals an instruction-retirement boundary. After it recognises the request, the block runs a fixed entry sequence. It first invalidates the pipeline. It then lets any outstanding bus cycle finish and waits for the external write buffers to drain. Once both are done it raises a level acknowledge. Next it hands off to a state-save unit, clears the interrupt and debug controls, and redirects fetch to the handler base address.

The acknowledge stays high for the whole of management mode, so system logic can route every memory access to the dedicated management memory. The handler base sits in a register with its own write port and resets to 0x0003_8000. Requests that arrive during the entry sequence or inside management mode are dropped. Only an exit strobe, honoured only in management mode, returns the block to normal operation.

Top module: `smm_entry_seq`

## Requirements
- R1: While reset is held and after it is released, every strobe output and `ack_o` are low and `pc_o` reads 0x0003_8000.
- R2: A request is recognised only in a cycle where `retire_i` is high. A request that arrived earlier stays pending until such a cycle. No retirement means no reaction.
- R3: `flush_o` is a one-cycle pulse in the cycle after recognition. It is always the first step of the sequence.
- R4: If a bus cycle is outstanding, `ack_o` stays low until that cycle has received all of its `rdy_i` beats. A burst (`cyc_burst_i`=1 at start) needs four beats and a single transfer needs one. A beat is counted from the cycle after the start onward.
- R5: `ack_o` rises in the cycle after one in which, once the flush has happened, the bus was idle and `wbuf_empty_i` was sampled high. It never rises while the buffers report non-empty.
- R6: `ack_o` stays high from its rise through the whole of management mode. It drops in the cycle after `exit_i` is sampled in management mode.
- R7: `save_valid_o` is high from the cycle `ack_o` rises until `save_done_i` is sampled high. It drops in the following cycle.
- R8: `clr_if_o`, `blk_nmi_o`, `clr_tf_o` and `clr_dbg_o` pulse together for exactly one cycle, in the cycle after the save completes.
- R9: `pc_load_o` pulses for one cycle, in the cycle after the clear strobes. `pc_o` then holds the handler base, and `ack_o` is high.
- R10: A write on `base_we_i` changes `pc_o` to `base_wdata_i` from the next cycle. Later entries jump to the written value.
- R11: Requests that arrive during the entry sequence or in management mode are ignored. After exit, no new sequence starts unless a new request arrives.
- R12: `exit_i` has no effect before management mode is reached: `ack_o` stays high and the sequence continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smi_req_i | input | 1 | Management interrupt request |
| retire_i | input | 1 | Instruction-retirement boundary this cycle |
| cyc_start_i | input | 1 | A bus cycle starts this cycle |
| cyc_burst_i | input | 1 | The starting cycle is a four-beat burst |
| rdy_i | input | 1 | Bus-ready beat |
| wbuf_empty_i | input | 1 | External write buffers empty |
| save_done_i | input | 1 | State-save unit finished |
| exit_i | input | 1 | Leave management mode |
| base_we_i | input | 1 | Handler base write enable |
| base_wdata_i | input | 32 | Handler base write data |
| flush_o | output | 1 | Pipeline invalidate strobe |
| ack_o | output | 1 | Management mode acknowledge (level) |
| save_valid_o | output | 1 | State-save request |
| clr_if_o | output | 1 | Clear maskable-interrupt enable |
| blk_nmi_o | output | 1 | Block non-maskable interrupts |
| clr_tf_o | output | 1 | Clear single-step trap flag |
| clr_dbg_o | output | 1 | Clear debug control and status |
| pc_load_o | output | 1 | Load new fetch address |
| pc_o | output | 32 | Handler entry address |

## Verification
The bench builds the block with its defaults: a 32-bit address, four-beat bursts and a reset base of 0x0003_8000. The four-beat burst lets the bench hold back the last beat and check that the acknowledge waits for it. It also keeps the write-buffer flag low after the bus is idle, which separates the two conditions that gate the acknowledge. A loadable 32-bit base lets one run confirm that both the reset value and a written value reach the jump.

// File: rtl/smm_pkg.sv
package smm_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_FLUSH,
        ST_DRAIN,
        ST_SAVE,
        ST_CLEAR,
        ST_JUMP,
        ST_SMM
    } seq_state_e;

    typedef struct packed {
        logic clr_if;
        logic blk_nmi;
        logic clr_tf;
        logic clr_dbg;
    } ctl_clear_t;

    localparam int unsigned DEF_ADDR_W      = 32;
    localparam int unsigned DEF_BURST_BEATS = 4;

    function automatic ctl_clear_t clear_all(input logic en);
        ctl_clear_t c;
        c.clr_if  = en;
        c.blk_nmi = en;
        c.clr_tf  = en;
        c.clr_dbg = en;
        return c;
    endfunction

endpackage

// File: rtl/smm_bus_tracker.sv
module smm_bus_tracker #(
    parameter int unsigned BURST_BEATS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic cyc_start_i,
    input  logic cyc_burst_i,
    input  logic rdy_i,
    output logic idle_o
);
    localparam int unsigned CNT_W = $clog2(BURST_BEATS + 1);

    generate
        if (BURST_BEATS == 1) begin : g_single
            logic busy_q;
            always_ff @(posedge clk) begin
                if (rst)              busy_q <= 1'b0;
                else if (cyc_start_i) busy_q <= 1'b1;
                else if (rdy_i)       busy_q <= 1'b0;
            end
            // cyc_burst_i has no meaning when every cycle is one beat
            logic burst_unused;
            assign burst_unused = cyc_burst_i;
            assign idle_o = !busy_q && !cyc_start_i;
        end else begin : g_count
            logic [CNT_W-1:0] cnt_q;
            always_ff @(posedge clk) begin
                if (rst)
                    cnt_q <= '0;
                else if (cyc_start_i)
                    cnt_q <= cyc_burst_i ? CNT_W'(BURST_BEATS) : CNT_W'(1);
                else if (rdy_i && cnt_q != '0)
                    cnt_q <= cnt_q - CNT_W'(1);
            end
            assign idle_o = (cnt_q == '0) && !cyc_start_i;

            // R4
            cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
                (cnt_q == '0 && !cyc_start_i) |=> (cnt_q == '0));
        end
    endgenerate

endmodule

// File: rtl/smm_base_reg.sv
module smm_base_reg #(
    parameter int unsigned    ADDR_W  = 32,
    parameter logic [ADDR_W-1:0] RST_VAL = ADDR_W'(32'h0003_8000)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] wdata_i,
    output logic [ADDR_W-1:0] base_o
);
    logic [ADDR_W-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst)       base_q <= RST_VAL;
        else if (we_i) base_q <= wdata_i;
    end

    assign base_o = base_q;

    // R10
    base_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we_i |=> $stable(base_o));

endmodule

// File: rtl/smm_entry_fsm.sv
module smm_entry_fsm
    import smm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       smi_req_i,
    input  logic       retire_i,
    input  logic       bus_idle_i,
    input  logic       wbuf_empty_i,
    input  logic       save_done_i,
    input  logic       exit_i,
    output logic       flush_o,
    output logic       ack_o,
    output logic       save_valid_o,
    output ctl_clear_t clr_o,
    output logic       pc_load_o
);
    seq_state_e state_q;
    logic       pend_q;
    logic       ack_q;
    logic       recog;

    assign recog = retire_i && (pend_q || smi_req_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            pend_q  <= 1'b0;
            ack_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_RUN: begin
                    if (recog) begin
                        state_q <= ST_FLUSH;
                        pend_q  <= 1'b0;
                    end else if (smi_req_i) begin
                        pend_q  <= 1'b1;
                    end
                end
                ST_FLUSH: state_q <= ST_DRAIN;
                ST_DRAIN: begin
                    if (bus_idle_i && wbuf_empty_i) begin
                        state_q <= ST_SAVE;
                        ack_q   <= 1'b1;
                    end
                end
                ST_SAVE:  if (save_done_i) state_q <= ST_CLEAR;
                ST_CLEAR: state_q <= ST_JUMP;
                ST_JUMP:  state_q <= ST_SMM;
                ST_SMM: begin
                    if (exit_i) begin
                        state_q <= ST_RUN;
                        ack_q   <= 1'b0;
                    end
                end
                default:  state_q <= ST_RUN;
            endcase
        end
    end

    always_comb begin
        flush_o      = (state_q == ST_FLUSH);
        save_valid_o = (state_q == ST_SAVE);
        clr_o        = clear_all(state_q == ST_CLEAR);
        pc_load_o    = (state_q == ST_JUMP);
        ack_o        = ack_q;
    end

    // R5
    ack_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_q) |-> ($past(wbuf_empty_i) && $past(bus_idle_i)));

    // R6
    ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_q && !exit_i) |=> ack_q);

    // R3
    flush_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        flush_o |=> !flush_o);

    // R8
    clear_order_chk: assert property (@(posedge clk) disable iff (rst)
        clr_o.clr_if |=> (pc_load_o && !clr_o.clr_if));

    // R7
    save_ack_chk: assert property (@(posedge clk) disable iff (rst)
        save_valid_o |-> ack_o);

endmodule

// File: rtl/smm_entry_seq.sv
module smm_entry_seq
    import smm_pkg::*;
#(
    parameter int unsigned       ADDR_W      = DEF_ADDR_W,
    parameter int unsigned       BURST_BEATS = DEF_BURST_BEATS,
    parameter logic [ADDR_W-1:0] BASE_RST    = ADDR_W'(32'h0003_8000)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smi_req_i,
    input  logic              retire_i,
    input  logic              cyc_start_i,
    input  logic              cyc_burst_i,
    input  logic              rdy_i,
    input  logic              wbuf_empty_i,
    input  logic              save_done_i,
    input  logic              exit_i,
    input  logic              base_we_i,
    input  logic [ADDR_W-1:0] base_wdata_i,
    output logic              flush_o,
    output logic              ack_o,
    output logic              save_valid_o,
    output logic              clr_if_o,
    output logic              blk_nmi_o,
    output logic              clr_tf_o,
    output logic              clr_dbg_o,
    output logic              pc_load_o,
    output logic [ADDR_W-1:0] pc_o
);
    logic       bus_idle;
    ctl_clear_t clr;

    smm_bus_tracker #(.BURST_BEATS(BURST_BEATS)) u_bus (
        .clk         (clk),
        .rst         (rst),
        .cyc_start_i (cyc_start_i),
        .cyc_burst_i (cyc_burst_i),
        .rdy_i       (rdy_i),
        .idle_o      (bus_idle)
    );

    smm_base_reg #(.ADDR_W(ADDR_W), .RST_VAL(BASE_RST)) u_base (
        .clk     (clk),
        .rst     (rst),
        .we_i    (base_we_i),
        .wdata_i (base_wdata_i),
        .base_o  (pc_o)
    );

    smm_entry_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .smi_req_i    (smi_req_i),
        .retire_i     (retire_i),
        .bus_idle_i   (bus_idle),
        .wbuf_empty_i (wbuf_empty_i),
        .save_done_i  (save_done_i),
        .exit_i       (exit_i),
        .flush_o      (flush_o),
        .ack_o        (ack_o),
        .save_valid_o (save_valid_o),
        .clr_o        (clr),
        .pc_load_o    (pc_load_o)
    );

    assign clr_if_o  = clr.clr_if;
    assign blk_nmi_o = clr.blk_nmi;
    assign clr_tf_o  = clr.clr_tf;
    assign clr_dbg_o = clr.clr_dbg;

    // R9
    load_ack_chk: assert property (@(posedge clk) disable iff (rst)
        pc_load_o |-> (ack_o && !save_valid_o));

endmodule

// File: tb/sim_smm_entry_seq.sv
module sim_smm_entry_seq;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smi_req_i = 0, retire_i = 0, cyc_start_i = 0, cyc_burst_i = 0, rdy_i = 0;
    logic wbuf_empty_i = 1, save_done_i = 0, exit_i = 0, base_we_i = 0;
    logic [31:0] base_wdata_i = '0;
    logic flush_o, ack_o, save_valid_o, clr_if_o, blk_nmi_o, clr_tf_o, clr_dbg_o, pc_load_o;
    logic [31:0] pc_o;

    always #5 clk = ~clk;

    smm_entry_seq u0 (
        .clk(clk), .rst(rst), .smi_req_i(smi_req_i), .retire_i(retire_i),
        .cyc_start_i(cyc_start_i), .cyc_burst_i(cyc_burst_i), .rdy_i(rdy_i),
        .wbuf_empty_i(wbuf_empty_i), .save_done_i(save_done_i), .exit_i(exit_i),
        .base_we_i(base_we_i), .base_wdata_i(base_wdata_i),
        .flush_o(flush_o), .ack_o(ack_o), .save_valid_o(save_valid_o),
        .clr_if_o(clr_if_o), .blk_nmi_o(blk_nmi_o), .clr_tf_o(clr_tf_o),
        .clr_dbg_o(clr_dbg_o), .pc_load_o(pc_load_o), .pc_o(pc_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Behavioural reference: phase 0 run, 1 invalidate, 2 wait bus, 3 save,
    // 4 clear, 5 jump, 6 management mode.
    int m_phase = 0;
    bit m_pend = 0;
    int m_beats = 0;
    bit m_ack = 0;
    logic [31:0] m_base = 32'h0003_8000;

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_phase = 0; m_pend = 0; m_beats = 0; m_ack = 0; m_base = 32'h0003_8000;
        end else begin
            bit idle;
            idle = (m_beats == 0) && !cyc_start_i;
            if (cyc_start_i) m_beats = cyc_burst_i ? 4 : 1;
            else if (rdy_i && m_beats > 0) m_beats = m_beats - 1;
            if (base_we_i) m_base = base_wdata_i;
            case (m_phase)
                0: if (retire_i && (m_pend || smi_req_i)) begin m_phase = 1; m_pend = 0; end
                   else if (smi_req_i) m_pend = 1;
                1: m_phase = 2;
                2: if (idle && wbuf_empty_i) begin m_phase = 3; m_ack = 1; end
                3: if (save_done_i) m_phase = 4;
                4: m_phase = 5;
                5: m_phase = 6;
                default: if (exit_i) begin m_phase = 0; m_ack = 0; end
            endcase
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk({31'd0, flush_o}, {31'd0, m_phase == 1}, "R3");
            chk({31'd0, ack_o}, {31'd0, m_ack}, "R5");
            chk({31'd0, save_valid_o}, {31'd0, m_phase == 3}, "R7");
            chk({28'd0, clr_if_o, blk_nmi_o, clr_tf_o, clr_dbg_o},
                (m_phase == 4) ? 32'hF : 32'h0, "R8");
            chk({31'd0, pc_load_o}, {31'd0, m_phase == 5}, "R9");
            chk(pc_o, m_base, "R10");
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        cyc(3);
        // R1 during reset
        chk({24'd0, flush_o, ack_o, save_valid_o, clr_if_o, blk_nmi_o, clr_tf_o, clr_dbg_o, pc_load_o},
            32'h0, "R1");
        chk(pc_o, 32'h0003_8000, "R1");
        rst = 0;
        cyc(1);
        chk({31'd0, ack_o}, 32'h0, "R1");

        // Scenario A: request without retirement is held pending
        smi_req_i = 1; cyc(1); smi_req_i = 0;
        cyc(4);
        chk({31'd0, flush_o}, 32'h0, "R2");
        retire_i = 1; cyc(1); retire_i = 0;
        chk({31'd0, flush_o}, 32'h1, "R2");
        cyc(3);
        save_done_i = 1; cyc(1); save_done_i = 0;
        cyc(4);
        chk({31'd0, ack_o}, 32'h1, "R6");
        smi_req_i = 1; retire_i = 1; cyc(1); smi_req_i = 0; retire_i = 0;
        cyc(3);
        chk({31'd0, flush_o}, 32'h0, "R11");
        exit_i = 1; cyc(1); exit_i = 0;
        chk({31'd0, ack_o}, 32'h0, "R6");
        retire_i = 1; cyc(5); retire_i = 0;
        chk({31'd0, flush_o | ack_o}, 32'h0, "R11");

        // Scenario B: burst in flight, buffers not empty
        cyc_start_i = 1; cyc_burst_i = 1; smi_req_i = 1; retire_i = 1; wbuf_empty_i = 0;
        cyc(1);
        cyc_start_i = 0; cyc_burst_i = 0; smi_req_i = 0; retire_i = 0;
        for (int i = 0; i < 3; i++) begin
            rdy_i = 1; cyc(1); rdy_i = 0; cyc(1);
        end
        wbuf_empty_i = 1;
        cyc(2);
        chk({31'd0, ack_o}, 32'h0, "R4");
        wbuf_empty_i = 0;
        rdy_i = 1; cyc(1); rdy_i = 0;
        cyc(3);
        chk({31'd0, ack_o}, 32'h0, "R5");
        wbuf_empty_i = 1;
        cyc(2);
        chk({31'd0, ack_o}, 32'h1, "R5");
        exit_i = 1; cyc(1); exit_i = 0;
        chk({31'd0, ack_o}, 32'h1, "R12");
        chk({31'd0, save_valid_o}, 32'h1, "R12");
        base_we_i = 1; base_wdata_i = 32'h0010_0000; cyc(1); base_we_i = 0;
        chk(pc_o, 32'h0010_0000, "R10");
        save_done_i = 1; cyc(1); save_done_i = 0;
        chk({28'd0, clr_if_o, blk_nmi_o, clr_tf_o, clr_dbg_o}, 32'hF, "R8");
        cyc(1);
        chk({31'd0, pc_load_o}, 32'h1, "R9");
        chk(pc_o, 32'h0010_0000, "R9");
        cyc(2);
        exit_i = 1; cyc(1); exit_i = 0;

        // Scenario C: single transfer, request earlier than retirement
        cyc_start_i = 1; smi_req_i = 1; cyc(1); cyc_start_i = 0; smi_req_i = 0;
        rdy_i = 1; cyc(1); rdy_i = 0;
        retire_i = 1; cyc(1); retire_i = 0;
        cyc(3);
        chk({31'd0, ack_o}, 32'h1, "R4");
        save_done_i = 1; cyc(1); save_done_i = 0;
        cyc(4);
        exit_i = 1; cyc(1); exit_i = 0;
        cyc(3);
        finish_run();
    end

    initial begin
        cyc(100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule